// File: doc/BRIEF.md
# Half-Duplex Deferral and Inter-Frame Gap Timer

This block decides, cycle by cycle, whether a transmitter may begin a frame. All timing is counted in bit times, and a single-cycle `bit_tick` strobe marks each one. The block measures the gap since the last transmission ended. It holds the transmitter off while the line carries traffic in half-duplex operation. When supervision is enabled, it raises an excessive-deferral abort if the transmitter has waited on a busy line for too long.

The minimum gap comes from a 3-bit code. Each step of the code removes 8 bit times from a 96 bit-time maximum. In half-duplex operation the gap never drops below 64 bit times. The deferral counter is not cumulative: a back-off restart, a grant or an abort returns it to zero. The abort threshold is larger when jumbo frames are enabled. Collision handling, back-off timing and the data path are handled outside the block.

Top module: `hd_defer_timer`

## Requirements
- R1: After synchronous reset, `defer_abort` is low, the deferral count is zero and the gap counter is saturated. A ready transmitter on a quiet line is therefore granted at once.
- R2: `tx_end` clears the gap counter, and it takes priority over a tick in the same cycle. Each later cycle with `bit_tick` high adds one. In full-duplex mode the required gap is 96 − 8·`ifg_code` ticks (code 0 = 96, code 7 = 40).
- R3: In half-duplex mode, codes 5, 6 and 7 all require 64 ticks. Codes 0 to 4 follow the R2 table.
- R4: In half-duplex mode, `tx_grant` is low while `crs` is high. In full-duplex mode, `crs` has no effect on the grant.
- R5: `tx_grant` is combinational. It is high exactly when `tx_ready` is high, the gap is met and the R4 carrier rule allows it.
- R6: A cycle is deferring when `tx_ready` and `crs` are high in half-duplex mode. With `defer_chk_en` high and jumbo off, the tick that occurs while the count already equals NORM_LIMIT produces a single-cycle `defer_abort` in the next cycle. That is tick number NORM_LIMIT+1. The abort also clears the count.
- R7: With `jumbo_en` high, the threshold in R6 is JUMBO_LIMIT instead of NORM_LIMIT.
- R8: With `defer_chk_en` low, `defer_abort` never rises, and the transmitter waits for as long as `crs` stays high.
- R9: `backoff_restart` clears the deferral count. It takes priority over an abort that would fall in the same cycle.
- R10: In full-duplex mode the deferral count does not advance and `defer_abort` never rises.
- R11: A grant clears the deferral count, so a later deferral needs a full threshold again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| crs | input | 1 | Carrier sense from the line |
| tx_ready | input | 1 | Transmitter has a frame waiting |
| tx_end | input | 1 | Pulse at the end of the last transmission |
| backoff_restart | input | 1 | Pulse after a back-off; clears the deferral count |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| ifg_code | input | 3 | Minimum gap code (0..7) |
| defer_chk_en | input | 1 | Enables excessive-deferral supervision |
| jumbo_en | input | 1 | Selects the larger deferral threshold |
| tx_grant | output | 1 | Transmitter may start a frame |
| defer_abort | output | 1 | One-cycle excessive-deferral abort |

## Verification
Two collisions are of interest.

The first is a back-off restart in the same cycle as the tick that would push the deferral count past its threshold. The bench builds a deferral that stops exactly at the threshold and then raises the restart together with the next tick. It expects no abort in the following cycle, and an abort only after a full new run of threshold+1 ticks.

The second is `tx_end` in the same cycle as a tick. Here the gap count must start from zero. A grant is then expected only after the full programmed gap, and the random phase produces this overlap repeatedly.

// File: rtl/hdd_pkg.sv
package hdd_pkg;

    localparam int GAP_MAX_BITS   = 96;
    localparam int GAP_STEP_BITS  = 8;
    localparam int HD_FLOOR_CODE  = 4;
    localparam int GAP_W          = $clog2(GAP_MAX_BITS + 1);

    typedef logic [2:0]       ifg_code_t;
    typedef logic [GAP_W-1:0] gap_cnt_t;

    typedef struct packed {
        logic ready;
        logic carrier;
        logic full_dup;
    } tx_ctx_t;

    // Required gap in bit times; half duplex clamps the code at the floor.
    function automatic gap_cnt_t gap_bits(input ifg_code_t code, input logic full_dup);
        int eff;
        eff = int'(code);
        if (!full_dup && eff > HD_FLOOR_CODE) eff = HD_FLOOR_CODE;
        return gap_cnt_t'(GAP_MAX_BITS - GAP_STEP_BITS * eff);
    endfunction

endpackage

// File: rtl/hdd_gap_tracker.sv
module hdd_gap_tracker
    import hdd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bit_tick,
    input  logic      tx_end,
    input  ifg_code_t ifg_code,
    input  logic      full_dup,
    output logic      gap_met
);
    gap_cnt_t since_end;
    gap_cnt_t need;

    always_ff @(posedge clk) begin
        if (rst)
            since_end <= gap_cnt_t'(GAP_MAX_BITS);
        else if (tx_end)
            since_end <= '0;
        else if (bit_tick && since_end < gap_cnt_t'(GAP_MAX_BITS))
            since_end <= since_end + 1'b1;
    end

    always_comb begin
        need    = gap_bits(ifg_code, full_dup);
        gap_met = (since_end >= need);
    end
endmodule

// File: rtl/hdd_defer_watch.sv
module hdd_defer_watch #(
    parameter int NORM_LIMIT  = 24288,
    parameter int JUMBO_LIMIT = 155680
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic deferring,
    input  logic chk_en,
    input  logic jumbo_en,
    input  logic restart,
    input  logic grant,
    output logic defer_abort
);
    localparam int TOP_LIMIT = (JUMBO_LIMIT > NORM_LIMIT) ? JUMBO_LIMIT : NORM_LIMIT;
    localparam int CW        = $clog2(TOP_LIMIT + 2);
    localparam logic [CW-1:0] SAT = CW'(TOP_LIMIT + 1);

    logic [CW-1:0] wait_cnt;
    logic [CW-1:0] limit;
    logic          overrun;

    always_comb begin
        limit   = jumbo_en ? CW'(JUMBO_LIMIT) : CW'(NORM_LIMIT);
        overrun = bit_tick && deferring && chk_en && !restart && (wait_cnt >= limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wait_cnt    <= '0;
            defer_abort <= 1'b0;
        end else begin
            defer_abort <= overrun;
            if (restart || grant || overrun)
                wait_cnt <= '0;
            else if (bit_tick && deferring && wait_cnt < SAT)
                wait_cnt <= wait_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hd_defer_timer.sv
module hd_defer_timer
    import hdd_pkg::*;
#(
    parameter int NORM_LIMIT  = 24288,
    parameter int JUMBO_LIMIT = 155680
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_tick,
    input  logic       crs,
    input  logic       tx_ready,
    input  logic       tx_end,
    input  logic       backoff_restart,
    input  logic       full_duplex,
    input  logic [2:0] ifg_code,
    input  logic       defer_chk_en,
    input  logic       jumbo_en,
    output logic       tx_grant,
    output logic       defer_abort
);
    tx_ctx_t ctx;
    logic    gap_met;
    logic    deferring;

    always_comb begin
        ctx.ready    = tx_ready;
        ctx.carrier  = crs;
        ctx.full_dup = full_duplex;
        deferring    = ctx.ready && ctx.carrier && !ctx.full_dup;
        tx_grant     = ctx.ready && (ctx.full_dup || !ctx.carrier) && gap_met;
    end

    hdd_gap_tracker u_gap (
        .clk      (clk),
        .rst      (rst),
        .bit_tick (bit_tick),
        .tx_end   (tx_end),
        .ifg_code (ifg_code),
        .full_dup (full_duplex),
        .gap_met  (gap_met)
    );

    hdd_defer_watch #(
        .NORM_LIMIT  (NORM_LIMIT),
        .JUMBO_LIMIT (JUMBO_LIMIT)
    ) u_defer (
        .clk         (clk),
        .rst         (rst),
        .bit_tick    (bit_tick),
        .deferring   (deferring),
        .chk_en      (defer_chk_en),
        .jumbo_en    (jumbo_en),
        .restart     (backoff_restart),
        .grant       (tx_grant),
        .defer_abort (defer_abort)
    );
endmodule

// File: rtl/hdd_checker.sv
module hdd_checker (
    input logic       clk,
    input logic       rst,
    input logic       bit_tick,
    input logic       crs,
    input logic       tx_ready,
    input logic       tx_end,
    input logic       backoff_restart,
    input logic       full_duplex,
    input logic [2:0] ifg_code,
    input logic       defer_chk_en,
    input logic       jumbo_en,
    input logic       tx_grant,
    input logic       defer_abort
);
    p_grant_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
        tx_grant |-> tx_ready);

    p_half_carrier_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_grant && !full_duplex) |-> !crs);

    p_gap_restarts_r2: assert property (@(posedge clk) disable iff (rst)
        tx_end |=> !tx_grant);

    p_abort_single_r6: assert property (@(posedge clk) disable iff (rst)
        defer_abort |=> !defer_abort);

    p_abort_needs_check_r8: assert property (@(posedge clk) disable iff (rst)
        defer_abort |-> $past(defer_chk_en && bit_tick));

    p_abort_half_only_r10: assert property (@(posedge clk) disable iff (rst)
        defer_abort |-> $past(!full_duplex && crs && tx_ready));

    p_restart_wins_r9: assert property (@(posedge clk) disable iff (rst)
        $past(backoff_restart) |-> !defer_abort);
endmodule

bind hd_defer_timer hdd_checker u_chk (.*);

// File: tb/hd_defer_timer_test.sv
module hd_defer_timer_test;
    localparam int CLK_P = 10;
    localparam int NL    = 40;
    localparam int JL    = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 0, crs = 0, tx_ready = 0, tx_end = 0, backoff_restart = 0;
    logic full_duplex = 0, defer_chk_en = 0, jumbo_en = 0;
    logic [2:0] ifg_code = 0;
    logic tx_grant, defer_abort;

    int checks = 0, fails = 0;
    int m_ifg, m_def;
    logic m_abort;

    always #(CLK_P/2) clk = ~clk;

    hd_defer_timer #(.NORM_LIMIT(NL), .JUMBO_LIMIT(JL)) uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .crs(crs), .tx_ready(tx_ready),
        .tx_end(tx_end), .backoff_restart(backoff_restart), .full_duplex(full_duplex),
        .ifg_code(ifg_code), .defer_chk_en(defer_chk_en), .jumbo_en(jumbo_en),
        .tx_grant(tx_grant), .defer_abort(defer_abort));

    function automatic int exp_gap(input logic [2:0] c, input logic fd);
        if (!fd && c > 3'd4) return 64;
        return 96 - 8 * int'(c);
    endfunction

    function automatic logic exp_grant();
        return tx_ready && (full_duplex || !crs) && (m_ifg >= exp_gap(ifg_code, full_duplex));
    endfunction

    task automatic cyc(input string tag);
        logic eg, dfr, ab;
        int lim;
        #(CLK_P/4);
        eg = exp_grant();
        checks++;
        if (tx_grant !== eg) begin
            fails++;
            $display("FAIL %s grant act=%0b exp=%0b t=%0t", tag, tx_grant, eg, $time);
        end
        checks++;
        if (defer_abort !== m_abort) begin
            fails++;
            $display("FAIL %s abort act=%0b exp=%0b t=%0t", tag, defer_abort, m_abort, $time);
        end
        @(posedge clk);
        dfr = tx_ready && crs && !full_duplex;
        lim = jumbo_en ? JL : NL;
        ab  = bit_tick && dfr && defer_chk_en && !backoff_restart && (m_def >= lim);
        m_abort = ab;
        if (backoff_restart || eg || ab) m_def = 0;
        else if (bit_tick && dfr && m_def < JL + 1) m_def++;
        if (tx_end) m_ifg = 0;
        else if (bit_tick && m_ifg < 96) m_ifg++;
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic end_pulse(input string tag);
        tx_end = 1; cyc(tag); tx_end = 0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_ifg = 96; m_def = 0; m_abort = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: quiet line, ready, granted immediately
        tx_ready = 1;
        run(3, "R1");

        // R2: full-duplex gap table, with tick coinciding with tx_end
        full_duplex = 1; bit_tick = 1;
        for (int c = 0; c < 8; c++) begin
            ifg_code = 3'(c);
            end_pulse("R2");
            run(100, "R2");
        end
        // R2: only ticks advance the gap
        ifg_code = 3'd7;
        end_pulse("R2");
        for (int i = 0; i < 90; i++) begin bit_tick = (i % 2 == 0); cyc("R2"); end

        // R3: half-duplex floor
        full_duplex = 0; bit_tick = 1;
        for (int c = 3; c < 8; c++) begin
            ifg_code = 3'(c);
            end_pulse("R3");
            run(70, "R3");
        end

        // R4/R5: carrier blocks in half, ignored in full; no ready no grant
        crs = 1; run(5, "R4");
        full_duplex = 1; run(5, "R4");
        tx_ready = 0; run(5, "R5");
        full_duplex = 0; crs = 0; run(5, "R5");

        // R6: abort at NL+1 ticks
        tx_ready = 1; crs = 1; defer_chk_en = 1;
        run(100, "R6");
        // R7: jumbo threshold
        crs = 0; run(2, "R7"); crs = 1; jumbo_en = 1;
        run(250, "R7");
        // R8: supervision off
        jumbo_en = 0; defer_chk_en = 0;
        run(300, "R8");
        // R9: restart exactly on the overrun tick
        crs = 0; run(2, "R9"); crs = 1; defer_chk_en = 1;
        run(NL, "R9");
        backoff_restart = 1; cyc("R9"); backoff_restart = 0;
        run(NL + 5, "R9");
        // R10: full duplex never defers
        full_duplex = 1; run(200, "R10");
        // R11: grant clears deferral count
        full_duplex = 0; run(NL - 5, "R11");
        crs = 0; run(2, "R11");
        crs = 1; run(NL + 5, "R11");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            bit_tick        = ($urandom % 3) == 0;
            tx_end          = ($urandom % 60) == 0;
            backoff_restart = ($urandom % 80) == 0;
            tx_ready        = ($urandom % 10) != 0;
            if (($urandom % 20) == 0) crs = ~crs;
            if (($urandom % 300) == 0) full_duplex = ~full_duplex;
            if (($urandom % 100) == 0) ifg_code = 3'($urandom % 8);
            if (($urandom % 200) == 0) defer_chk_en = ~defer_chk_en;
            if (($urandom % 300) == 0) jumbo_en = ~jumbo_en;
            cyc("R2-R11 random");
        end
        // R6 tag retained for random coverage of aborts
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule